// File: doc/BRIEF.md
# Sampled-Entropy Random Bit Collector

This block is the register-mapped front end of a true random number generator. An external source provides one raw entropy bit, standing in for a free-running ring oscillator. While a collection runs, the block samples that bit once every programmable number of clock cycles. Each sample goes into a result buffer that holds up to 256 bits. Software drives everything through a simple register bus with a write strobe, an address, write data and registered read data.

To use the block, software programs the period between samples. It then enables the generator and picks the result length and an oscillator speed code. The speed code only goes out on a port to the entropy source. A collection begins when software sets the start flag. Software polls until the hardware drops that flag, then reads back up to eight 32-bit result words. The control word is written through a per-bit mask, so one field can change without a read-modify-write.

Top module: `entropy_collector`

## Requirements
- R1: A write to the control register (offset 0x400) changes a control bit i (i in 0..5) only when bit 16+i of the written word is 1. All other control bits keep their value.
- R2: Control bits [5:4] select the collection length: code 0 gives 64 bits, 1 gives 128, 2 gives 192 and 3 gives 256. Exactly that many bits are gathered before the collection ends.
- R3: The register at offset 0x404 holds a period P. After the collection starts, the n-th bit (n from 0) is the entropy input seen at the clock edge P*(n+1) cycles after the edge that accepted the start write.
- R4: Control bit 0 (start) reads 1 while a collection runs. The hardware clears it on the edge that captures the last bit.
- R5: The result words are read at offsets 0x410 + 4*k for k = 0..7. Reads of unmapped offsets return 0. Read data appears one clock after the address.
- R6: A control write of value 0 under a full mask (0xFFFF0000) clears the enable and the start flag and abandons the running collection. The result words keep their last completed values.
- R7: A start request while control bit 1 (enable) is 0 is ignored, and start reads back as 0.
- R8: When a collection starts, result words beyond the selected length are cleared to 0. Words inside the length keep their previous values until the collection completes.
- R9: A period of 0 behaves like a period of 1: one bit is captured on every clock.
- R10: Control bits [3:2] appear on `osc_speed` and control bit 1 appears on `osc_enable`. The speed code has no effect on sampling.
- R11: Captured bits fill word 0 from its least significant bit upward, then words 1, 2 and so on in ascending order.
- R12: After reset, the control register, the period register and all result words read 0, and both oscillator ports are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data; the control register takes its mask in bits [21:16] |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| entropy_in | input | 1 | Raw entropy bit, synchronous to clk |
| osc_enable | output | 1 | Enable for the entropy source |
| osc_speed | output | 2 | Speed code for the entropy source |

## Verification
The entropy input follows a hashed function of the cycle count. Each result bit therefore reveals which clock edge it was taken at, and in which word and bit position it landed. The runs use a period of 1 at full length, a period of 0 at 128 bits, and a period of 5 at 64 bits. These runs separate an off-by-one in the period counter, a wrong handling of period 0, and a wrong length decode or bit order. A short run that follows a longer one shows that words beyond the new length are cleared, while words inside it still hold old data until the run completes. Masked writes that touch one field at a time, a start request with enable clear, and a full-mask stop during a long run cover the control path.

// File: rtl/ecol_pkg.sv
package ecol_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] A_CTL  = 12'h400;
  localparam logic [ADDR_W-1:0] A_PER  = 12'h404;
  localparam logic [ADDR_W-1:0] A_DATA = 12'h410;
  localparam int CTL_W = 6;

  // packed order gives bit 0 = start, 1 = enable, [3:2] speed, [5:4] length
  typedef struct packed {
    logic [1:0] len;
    logic [1:0] speed;
    logic       enable;
    logic       start;
  } ctl_t;
endpackage

// File: rtl/ecol_timer.sv
module ecol_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] eff;

  always_comb begin
    eff = (period == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : period;
    tick = run && (cnt >= eff - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R3: with an unchanged period above 1, two captures are never back to back
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && $past(tick) && $stable(period) && period > 1) |-> !tick);
endmodule

// File: rtl/ecol_collector.sv
module ecol_collector #(
  parameter int DW     = 32,
  parameter int NWORDS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               begin_i,
  input  logic [1:0]         len_i,
  input  logic               busy,
  input  logic               tick,
  input  logic               bit_in,
  output logic               done,
  output logic [DW*NWORDS-1:0] data_o
);
  localparam int TOT   = DW * NWORDS;
  localparam int IDX_W = $clog2(TOT);
  localparam int STEP  = TOT / 4;
  localparam int WPS   = NWORDS / 4;

  logic [1:0]       len_q;
  logic [IDX_W-1:0] bitcnt;
  logic [IDX_W:0]   nbits;
  logic [TOT-1:0]   shadow, shadow_nx;
  logic             cap;

  always_comb begin
    nbits     = (IDX_W+1)'((int'(len_q) + 1) * STEP);
    cap       = busy && tick;
    done      = cap && ({1'b0, bitcnt} == nbits - 1'b1);
    shadow_nx = shadow;
    if (cap) shadow_nx[bitcnt] = bit_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= '0;
      bitcnt <= '0;
      shadow <= '0;
    end else if (begin_i) begin
      len_q  <= len_i;
      bitcnt <= '0;
    end else if (cap) begin
      shadow <= shadow_nx;
      bitcnt <= bitcnt + 1'b1;
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        data_o[w*DW +: DW] <= '0;
      else if (begin_i && w >= (int'(len_i) + 1) * WPS)
        data_o[w*DW +: DW] <= '0;
      else if (done && w < (int'(len_q) + 1) * WPS)
        data_o[w*DW +: DW] <= shadow_nx[w*DW +: DW];
    end
  end

  p_bitcnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> ({1'b0, bitcnt} < nbits));
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !begin_i) |=> $stable(data_o));
  p_begin_idle_r4: assert property (@(posedge clk) disable iff (rst)
    begin_i |-> !busy);
endmodule

// File: rtl/entropy_collector.sv
module entropy_collector
  import ecol_pkg::*;
#(
  parameter int NWORDS = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              entropy_in,
  output logic              osc_enable,
  output logic [1:0]        osc_speed
);
  localparam int DW = 32;
  localparam int IW = $clog2(NWORDS);

  ctl_t             ctl_q, ctl_n;
  logic [CNT_W-1:0] per_q;
  logic             wr_ctl, wr_per, tick, done, begin_c;
  logic [CTL_W-1:0] mask, wval;
  logic [DW*NWORDS-1:0] data;
  logic [ADDR_W-1:0]    off;

  always_comb begin
    wr_ctl = bus_we && bus_addr == A_CTL;
    wr_per = bus_we && bus_addr == A_PER;
    mask   = bus_wdata[16 +: CTL_W];
    wval   = bus_wdata[CTL_W-1:0];
    ctl_n  = ctl_q;
    if (wr_ctl) ctl_n = ctl_t'((ctl_q & ~mask) | (wval & mask));
    if (done) ctl_n.start = 1'b0;
    if (!ctl_n.enable) ctl_n.start = 1'b0;
    begin_c = ctl_n.start && !ctl_q.start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      per_q <= '0;
    end else begin
      ctl_q <= ctl_n;
      if (wr_per) per_q <= CNT_W'(bus_wdata);
    end
  end

  ecol_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .run(ctl_q.start), .period(per_q), .tick(tick)
  );

  ecol_collector #(.DW(DW), .NWORDS(NWORDS)) u_coll (
    .clk(clk), .rst(rst), .begin_i(begin_c), .len_i(ctl_n.len),
    .busy(ctl_q.start), .tick(tick), .bit_in(entropy_in),
    .done(done), .data_o(data)
  );

  assign osc_enable = ctl_q.enable;
  assign osc_speed  = ctl_q.speed;
  assign off        = bus_addr - A_DATA;

  always_ff @(posedge clk) begin
    if (rst)                     bus_rdata <= '0;
    else if (bus_addr == A_CTL)  bus_rdata <= 32'(ctl_q);
    else if (bus_addr == A_PER)  bus_rdata <= 32'(per_q);
    else if (off < ADDR_W'(4 * NWORDS) && off[1:0] == 2'b00)
      bus_rdata <= data[off[IW+1:2]*DW +: DW];
    else                         bus_rdata <= '0;
  end

  p_start_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
    ctl_q.start |-> ctl_q.enable);
  p_start_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.start && !done && !wr_ctl) |=> ctl_q.start);
  p_start_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.start && done) |=> !ctl_q.start);
endmodule

// File: tb/entropy_collector_tb.sv
module entropy_collector_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1, bus_we = 0, entropy_in = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic osc_enable;
  logic [1:0] osc_speed;
  int unsigned tick = 0;
  int n_chk = 0, n_fail = 0;
  logic [31:0] expw [8];
  logic [31:0] r, w0_hold;
  int unsigned st;

  entropy_collector u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .entropy_in(entropy_in),
    .osc_enable(osc_enable), .osc_speed(osc_speed)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  function automatic logic ent(int unsigned t);
    logic [31:0] h;
    h = t * 32'h9E3779B1;
    return h[31] ^ h[17] ^ h[5];
  endfunction
  always @(negedge clk) entropy_in <= ent(tick);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, output int unsigned t);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d; t = tick;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // expected words from the requirements: bit n at edge st+P*(n+1), word n/32, bit n%32
  task automatic build_exp(input int unsigned s, input int p, input int nbits);
    int pe;
    pe = (p == 0) ? 1 : p;
    for (int k = 0; k < 8; k++) expw[k] = '0;
    for (int n = 0; n < nbits; n++) expw[n/32][n%32] = ent(s + pe * (n + 1));
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    int guard = 0;
    v = 1;
    while (v[0] && guard < 5000) begin
      rd(12'h400, v);
      guard++;
    end
    chk(!v[0], req, v, 32'h0);
  endtask

  task automatic t_reset;
    int unsigned t;
    rd(12'h400, r); chk(r == 0, "R12 ctl", r, 0);
    rd(12'h404, r); chk(r == 0, "R12 period", r, 0);
    rd(12'h41C, r); chk(r == 0, "R12 data7", r, 0);
    chk({osc_enable, osc_speed} == 0, "R12 ports", {osc_enable, osc_speed}, 0);
    t = 0;
  endtask

  task automatic t_masked;
    int unsigned t;
    wr(12'h404, 32'd5, t); rd(12'h404, r); chk(r == 5, "R5 period rw", r, 5);
    wr(12'h400, 32'h000C_003F, t); rd(12'h400, r); chk(r == 32'h0C, "R1 speed only", r, 32'h0C);
    chk(osc_speed == 2'd3 && !osc_enable, "R10 ports", {osc_enable, osc_speed}, 3'b011);
    wr(12'h400, 32'h0030_0030, t); rd(12'h400, r); chk(r == 32'h3C, "R1 len only", r, 32'h3C);
    rd(12'h408, r); chk(r == 0, "R5 unmapped", r, 0);
  endtask

  task automatic t_start_disabled;
    int unsigned t;
    wr(12'h400, 32'h0001_0001, t); rd(12'h400, r);
    chk(r[0] == 0, "R7 start ignored", r, 32'h3C);
  endtask

  task automatic t_run_full;
    wr(12'h404, 32'd1, st);
    wr(12'h400, 32'h003F_0026, st);            // len 2, speed 1, enable
    wr(12'h400, 32'h0031_0031, st);            // len 3 + start together
    wait_done("R4 done 256");
    build_exp(st, 1, 256);
    for (int k = 0; k < 8; k++) begin
      rd(12'h410 + 12'(4 * k), r);
      chk(r == expw[k], "R2 R3 R11 word 256", r, expw[k]);
    end
  endtask

  task automatic t_run_p0;
    int unsigned t;
    wr(12'h404, 32'd0, t);
    wr(12'h400, 32'h0031_0011, st);            // len 1, start
    wait_done("R4 done 128");
    build_exp(st, 0, 128);
    for (int k = 0; k < 8; k++) begin
      rd(12'h410 + 12'(4 * k), r);
      chk(r == expw[k], "R9 R8 word 128", r, expw[k]);
    end
    w0_hold = expw[0];
  endtask

  task automatic t_run_short;
    int unsigned t;
    wr(12'h404, 32'd5, t);
    wr(12'h400, 32'h0031_0001, st);            // len 0, start
    rd(12'h400, r); chk(r[0] == 1, "R4 busy", r, 1);
    rd(12'h410, r); chk(r == w0_hold, "R8 hold during run", r, w0_hold);
    wait_done("R4 done 64");
    build_exp(st, 5, 64);
    for (int k = 0; k < 4; k++) begin
      rd(12'h410 + 12'(4 * k), r);
      chk(r == expw[k], "R3 R2 word 64", r, expw[k]);
    end
    w0_hold = expw[0];
  endtask

  task automatic t_stop;
    int unsigned t;
    wr(12'h404, 32'd50, t);
    wr(12'h400, 32'h0031_0031, t);
    repeat (100) @(negedge clk);
    wr(12'h400, 32'hFFFF_0000, t);
    rd(12'h400, r); chk(r == 0, "R6 ctl cleared", r, 0);
    chk(!osc_enable, "R6 enable port", {31'b0, osc_enable}, 0);
    repeat (300) @(negedge clk);
    rd(12'h410, r); chk(r == w0_hold, "R6 data kept", r, w0_hold);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_masked();
    t_start_disabled();
    t_run_full();
    t_run_p0();
    t_run_short();
    t_stop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule